// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block sends asynchronous serial frames from a single-entry holding register. A host places a word into the holding register through a one-cycle write strobe. When transmission is enabled, the word moves into the frame sequencer, which puts it on the line one bit per baud tick. A status output reports when the holding register is free. An interrupt request follows that status whenever the interrupt is enabled.

The frame format is chosen from inputs at the moment a word is handed to the sequencer:
- 7 or 8 data bits;
- LSB-first or MSB-first order;
- optional even or odd parity;
- one or two stop bits.

The holding register frees up as soon as its word is handed over. The host can therefore load the next word while the current frame is still on the line. Frames then follow each other with no idle gap.

Top module: `ser_tx_hold`

## Requirements
- R1: After reset `hold_empty` is 1, `txd` is 1 and no frame is in progress.
- R2: A write (`wr_en`=1) is accepted only while `hold_empty` is 1. An accepted write clears `hold_empty` on the next cycle. A write made while `hold_empty` is 0 changes nothing: the word already held is the one sent.
- R3: While `tx_enable` is 0, a held word stays in the holding register, `hold_empty` stays 0 and an idle line stays at 1.
- R4: `irq` equals `irq_enable` AND `hold_empty`. Because `hold_empty` resets to 1, setting `irq_enable` raises `irq` at once.
- R5: A held word is handed to the sequencer when `tx_enable` is 1 and the sequencer is idle or finishing its final stop bit. `hold_empty` returns to 1 on the cycle after the handover.
- R6: A frame is a start bit of 0, the data bits, the optional parity bit, then one stop bit of 1 (`fmt_two_stop`=0) or two (`fmt_two_stop`=1). `txd` changes only on the clock edge where `baud_tick` is 1. The start bit begins at the first tick after the handover.
- R7: With `fmt_len7`=1, seven data bits are sent and bit 7 of the written word is never sent, in either bit order. With `fmt_msb_first`=0 the bits go out from bit 0 upward. With `fmt_msb_first`=1 they go out from the highest sent bit downward.
- R8: With `fmt_par_en`=1, one parity bit follows the data. It is the XOR of the sent data bits when `fmt_par_odd`=0, and the inverse of that XOR when `fmt_par_odd`=1.
- R9: If a word is already held when the final stop bit ends, its start bit begins on that same tick, with no idle bit between the two frames.
- R10: Clearing `tx_enable` during a frame lets that frame complete unchanged. After that the line stays at 1 and any held word waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable | input | 1 | Allows held words to be handed to the sequencer |
| irq_enable | input | 1 | Gates the interrupt request |
| fmt_len7 | input | 1 | 1: seven data bits, 0: DATA_W data bits |
| fmt_par_en | input | 1 | Appends a parity bit |
| fmt_par_odd | input | 1 | 1: odd parity, 0: even parity |
| fmt_msb_first | input | 1 | 1: MSB first, 0: LSB first |
| fmt_two_stop | input | 1 | 1: two stop bits, 0: one stop bit |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | DATA_W | Host write word |
| hold_empty | output | 1 | Holding register free |
| irq | output | 1 | Transmit interrupt request |
| txd | output | 1 | Serial line output, idle high |

## Verification
The properties assume a `baud_tick` that is a clean single-cycle pulse. They also assume that the host may strobe `wr_en` in any cycle, including while the holding register is full, since such writes must be ignored. The format inputs are captured at handover, so the properties place no stability demand on them. The stimulus raises `baud_tick` on exactly one cycle in four, so every bit lasts four clocks. It changes inputs only on falling clock edges. It sweeps every format combination over several data words, with both bit-7 values, and writes while full on purpose.

// File: rtl/sth_pkg.sv
package sth_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_WAIT  = 3'd1,
      PH_START = 3'd2,
      PH_DATA  = 3'd3,
      PH_PAR   = 3'd4,
      PH_STOP  = 3'd5
   } tx_phase_t;

   typedef struct packed {
      logic len_short;
      logic par_en;
      logic par_odd;
      logic msb_first;
      logic two_stop;
   } tx_fmt_t;

endpackage

// File: rtl/sth_hold_reg.sv
module sth_hold_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic [DATA_W-1:0] held_data,
   output logic              empty
);

   logic [DATA_W-1:0] data_q;
   logic              empty_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q  <= '0;
         empty_q <= 1'b1;
      end else if (empty_q) begin
         if (wr_en) begin
            data_q  <= wr_data;
            empty_q <= 1'b0;
         end
      end else if (take) begin
         empty_q <= 1'b1;
      end
   end

   assign held_data = data_q;
   assign empty     = empty_q;

endmodule

// File: rtl/sth_frame_data.sv
module sth_frame_data
   import sth_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [DATA_W-1:0] held_data,
   input  tx_fmt_t           fmt_live,
   input  logic [IDX_W-1:0]  sel_idx,
   output logic              data_bit,
   output logic              par_bit
);

   logic [DATA_W-1:0] send_mask;
   logic [DATA_W-1:0] word_q;
   logic              par_q;

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      if (i == DATA_W - 1) begin : g_top
         assign send_mask[i] = ~fmt_live.len_short;
      end else begin : g_low
         assign send_mask[i] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         par_q  <= 1'b0;
      end else if (take) begin
         word_q <= held_data & send_mask;
         par_q  <= (^(held_data & send_mask)) ^ fmt_live.par_odd;
      end
   end

   assign data_bit = word_q[sel_idx];
   assign par_bit  = par_q;

endmodule

// File: rtl/sth_sequencer.sv
module sth_sequencer
   import sth_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             baud_tick,
   input  logic             take,
   input  tx_fmt_t          fmt_live,
   input  logic             data_bit,
   input  logic             par_bit,
   output logic [IDX_W-1:0] sel_idx,
   output logic             ready,
   output logic             active,
   output logic             txd
);

   localparam logic [IDX_W-1:0] IDX_LAST_FULL  = IDX_W'(DATA_W - 1);
   localparam logic [IDX_W-1:0] IDX_LAST_SHORT = IDX_W'(DATA_W - 2);

   tx_phase_t        phase_q;
   tx_fmt_t          fmt_q;
   logic [IDX_W-1:0] idx_q;
   logic             stop_more_q;
   logic             txd_q;

   logic [IDX_W-1:0] top_idx;
   logic [IDX_W-1:0] first_idx;
   logic             last_data;
   logic             last_stop;

   assign top_idx   = fmt_q.len_short ? IDX_LAST_SHORT : IDX_LAST_FULL;
   assign first_idx = fmt_live.msb_first ? (fmt_live.len_short ? IDX_LAST_SHORT : IDX_LAST_FULL)
                                         : '0;
   assign last_data = fmt_q.msb_first ? (idx_q == '0) : (idx_q == top_idx);
   assign last_stop = (phase_q == PH_STOP) && !stop_more_q;
   assign ready     = (phase_q == PH_IDLE) || (last_stop && baud_tick);
   assign active    = (phase_q != PH_IDLE);

   always_comb begin
      sel_idx = idx_q;
      if (phase_q == PH_DATA) begin
         sel_idx = fmt_q.msb_first ? idx_q - 1'b1 : idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         fmt_q       <= '0;
         idx_q       <= '0;
         stop_more_q <= 1'b0;
         txd_q       <= 1'b1;
      end else begin
         if (take) begin
            fmt_q <= fmt_live;
            idx_q <= first_idx;
         end
         unique case (phase_q)
            PH_IDLE: begin
               if (take) phase_q <= PH_WAIT;
            end
            PH_WAIT: begin
               if (baud_tick) begin
                  txd_q   <= 1'b0;
                  phase_q <= PH_START;
               end
            end
            PH_START: begin
               if (baud_tick) begin
                  txd_q   <= data_bit;
                  phase_q <= PH_DATA;
               end
            end
            PH_DATA: begin
               if (baud_tick) begin
                  if (last_data) begin
                     if (fmt_q.par_en) begin
                        txd_q   <= par_bit;
                        phase_q <= PH_PAR;
                     end else begin
                        txd_q       <= 1'b1;
                        stop_more_q <= fmt_q.two_stop;
                        phase_q     <= PH_STOP;
                     end
                  end else begin
                     txd_q <= data_bit;
                     idx_q <= sel_idx;
                  end
               end
            end
            PH_PAR: begin
               if (baud_tick) begin
                  txd_q       <= 1'b1;
                  stop_more_q <= fmt_q.two_stop;
                  phase_q     <= PH_STOP;
               end
            end
            PH_STOP: begin
               if (baud_tick) begin
                  if (stop_more_q) begin
                     stop_more_q <= 1'b0;
                  end else if (take) begin
                     txd_q   <= 1'b0;
                     phase_q <= PH_START;
                  end else begin
                     phase_q <= PH_IDLE;
                  end
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign txd = txd_q;

endmodule

// File: rtl/ser_tx_hold.sv
module ser_tx_hold
   import sth_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_enable,
   input  logic              irq_enable,
   input  logic              fmt_len7,
   input  logic              fmt_par_en,
   input  logic              fmt_par_odd,
   input  logic              fmt_msb_first,
   input  logic              fmt_two_stop,
   input  logic              baud_tick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              hold_empty,
   output logic              irq,
   output logic              txd
);

   localparam int IDX_W = $clog2(DATA_W);

   if (DATA_W < 2 || DATA_W > 16) begin : g_bad_width
      $error("ser_tx_hold: DATA_W must lie in 2..16");
   end

   tx_fmt_t           fmt_live;
   logic [DATA_W-1:0] held_data;
   logic              empty;
   logic              take;
   logic              seq_ready;
   logic              tx_active;
   logic [IDX_W-1:0]  sel_idx;
   logic              data_bit;
   logic              par_bit;

   assign fmt_live = '{len_short: fmt_len7, par_en: fmt_par_en, par_odd: fmt_par_odd,
                       msb_first: fmt_msb_first, two_stop: fmt_two_stop};

   assign take = tx_enable && !empty && seq_ready;

   sth_hold_reg #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .take      (take),
      .held_data (held_data),
      .empty     (empty)
   );

   sth_frame_data #(.DATA_W(DATA_W)) u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .held_data (held_data),
      .fmt_live  (fmt_live),
      .sel_idx   (sel_idx),
      .data_bit  (data_bit),
      .par_bit   (par_bit)
   );

   sth_sequencer #(.DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .take      (take),
      .fmt_live  (fmt_live),
      .data_bit  (data_bit),
      .par_bit   (par_bit),
      .sel_idx   (sel_idx),
      .ready     (seq_ready),
      .active    (tx_active),
      .txd       (txd)
   );

   assign hold_empty = empty;
   assign irq        = irq_enable && empty;

endmodule

// File: rtl/ser_tx_hold_chk.sv
module ser_tx_hold_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_enable,
   input logic irq_enable,
   input logic baud_tick,
   input logic wr_en,
   input logic hold_empty,
   input logic irq,
   input logic txd,
   input logic tx_active
);

   a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_active |-> txd);

   a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hold_empty) |=> !hold_empty);

   a_r3_disabled_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_enable && !hold_empty) |=> !hold_empty);

   a_r4_irq_tracks_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (irq_enable && hold_empty));

   a_r5_free_means_sending: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_empty) |-> tx_active);

   a_r6_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_tick |=> $stable(txd));

endmodule

bind ser_tx_hold ser_tx_hold_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_enable  (tx_enable),
   .irq_enable (irq_enable),
   .baud_tick  (baud_tick),
   .wr_en      (wr_en),
   .hold_empty (hold_empty),
   .irq        (irq),
   .txd        (txd),
   .tx_active  (tx_active)
);

// File: tb/ser_tx_hold_test.sv
module ser_tx_hold_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_enable = 1'b0;
   logic       irq_enable = 1'b0;
   logic [4:0] cfg = '0;
   logic       baud_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       hold_empty, irq, txd;

   int n_checks = 0;
   int n_fail   = 0;
   int tick_cnt = 0;

   always #4 clk = ~clk;

   ser_tx_hold #(.DATA_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .irq_enable(irq_enable),
      .fmt_len7(cfg[0]), .fmt_par_en(cfg[1]), .fmt_par_odd(cfg[2]),
      .fmt_msb_first(cfg[3]), .fmt_two_stop(cfg[4]), .baud_tick(baud_tick),
      .wr_en(wr_en), .wr_data(wr_data), .hold_empty(hold_empty), .irq(irq), .txd(txd)
   );

   always @(negedge clk) begin
      tick_cnt  <= (tick_cnt + 1) % 4;
      baud_tick <= (tick_cnt == 3);
   end

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // cfg: [0] seven bits, [1] parity on, [2] odd, [3] msb first, [4] two stops
   function automatic int build(input logic [7:0] d, input logic [4:0] c, output logic [31:0] bits);
      int n = 0;
      int len = c[0] ? 7 : 8;
      bits = '0;
      bits[n++] = 1'b0;
      for (int k = 0; k < len; k++) bits[n++] = d[c[3] ? len - 1 - k : k];
      if (c[1]) bits[n++] = (^(d & (c[0] ? 8'h7f : 8'hff))) ^ c[2];
      bits[n++] = 1'b1;
      if (c[4]) bits[n++] = 1'b1;
      return n;
   endfunction

   task automatic write_word(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic capture(input int n, output logic [31:0] got);
      int guard = 0;
      got = '1;
      while (txd !== 1'b0 && guard < 400) begin
         @(negedge clk);
         guard++;
      end
      got[0] = txd;
      for (int i = 1; i < n; i++) begin
         repeat (4) @(negedge clk);
         got[i] = txd;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      logic [31:0] got, exp, exp2;
      int n, n2;
      logic [7:0] pats [4] = '{8'hA5, 8'h3C, 8'h81, 8'h7E};
      logic line_ok;

      repeat (3) @(negedge clk);
      check("R1 empty", hold_empty, 1);
      check("R1 line", txd, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 empty after", hold_empty, 1);
      check("R4 irq off", irq, 0);
      irq_enable = 1'b1;
      #1 check("R4 irq at once", irq, 1);

      // R2/R3: load while disabled, then write while full
      write_word(8'hA5);
      check("R2 flag cleared", hold_empty, 0);
      check("R4 irq drops", irq, 0);
      write_word(8'h3C);
      line_ok = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (txd !== 1'b1 || hold_empty !== 1'b0) line_ok = 1'b0;
      end
      check("R3 disabled holds", line_ok, 1);
      tx_enable = 1'b1;
      @(negedge clk);
      check("R5 flag returns", hold_empty, 1);
      n = build(8'hA5, cfg, exp);
      capture(n, got);
      check("R2 full write ignored", got, exp | ~((32'd1 << n) - 1));

      // R6/R7/R8: full format sweep
      for (int c = 0; c < 32; c++) begin
         for (int p = 0; p < 4; p++) begin
            repeat (12) @(negedge clk);
            cfg = c[4:0];
            write_word(pats[p]);
            n = build(pats[p], cfg, exp);
            capture(n, got);
            check($sformatf("R6 R7 R8 cfg %0d", c), got, exp | ~((32'd1 << n) - 1));
         end
      end

      // R7: bit 7 never sent in seven-bit mode, both orders
      for (int m = 0; m < 2; m++) begin
         repeat (12) @(negedge clk);
         cfg = {1'b0, m[0], 3'b001};
         write_word(8'hD2);
         n = build(8'h52, cfg, exp);
         capture(n, got);
         check("R7 bit7 dropped", got, exp | ~((32'd1 << n) - 1));
      end

      // R9: back to back frames without a gap
      repeat (12) @(negedge clk);
      cfg = 5'b10010;
      write_word(8'h96);
      while (hold_empty !== 1'b1) @(negedge clk);
      write_word(8'h0F);
      n  = build(8'h96, cfg, exp);
      n2 = build(8'h0F, cfg, exp2);
      capture(n + n2, got);
      check("R9 seamless", got, ((exp2 << n) | exp) | ~((32'd1 << (n + n2)) - 1));

      // R10: disable mid-frame, frame completes, next word waits
      repeat (12) @(negedge clk);
      cfg = 5'b00000;
      write_word(8'hC3);
      n = build(8'hC3, cfg, exp);
      begin
         int guard = 0;
         got = '1;
         while (txd !== 1'b0 && guard < 400) begin @(negedge clk); guard++; end
         got[0] = txd;
         for (int i = 1; i < n; i++) begin
            repeat (4) @(negedge clk);
            got[i] = txd;
            if (i == 3) begin
               tx_enable = 1'b0;
               wr_en = 1'b1; wr_data = 8'h5A;
               @(negedge clk); wr_en = 1'b0;
               repeat (3) @(negedge clk);
               i++;
               got[i] = txd;
            end
         end
      end
      check("R10 frame completes", got, exp | ~((32'd1 << n) - 1));
      line_ok = 1'b1;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (txd !== 1'b1) line_ok = 1'b0;
      end
      check("R10 line idle", line_ok, 1);
      check("R10 word waits", hold_empty, 0);
      tx_enable = 1'b1;
      n = build(8'h5A, cfg, exp);
      capture(n, got);
      check("R3 held word sent later", got, exp | ~((32'd1 << n) - 1));

      irq_enable = 1'b0;
      #1 check("R4 irq gated", irq, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule